// File: doc/BRIEF.md
# Paired-Mode Floating-Point Register File

This block holds thirty-two 64-bit floating-point registers behind two combinational read ports and one clocked write port. Every access carries a 5-bit register index and a width flag that says whether the access is 32 bits (single or word) or 64 bits (double or long). A mode input sets how indices map onto storage.

With `wideRegs` high, every index names its own 64-bit entry. With `wideRegs` low, the file runs in a 32-bit compatibility layout. A 32-bit value at an odd index lives in the upper half of the even entry below it, and a 64-bit access always lands on the even entry. A 32-bit write changes only one half of an entry and keeps the other half, so the caller never has to do a read-modify-write of its own.

Top module: `fpr_pair_file`

## Requirements
- R1: After reset, every entry reads as zero, through a 64-bit read and through a 32-bit read.
- R2: With `wideRegs` high, a 32-bit read of index x returns the low 32 bits of entry x on data bits [31:0], and bits [63:32] of the read data are zero.
- R3: With `wideRegs` low, a 32-bit read of an even index x returns the low half of entry x. A 32-bit read of an odd index x returns the upper half of entry x with bit 0 cleared. In both cases the value appears on bits [31:0], and bits [63:32] are zero.
- R4: A 32-bit write that maps to the low half of an entry stores `wrData[31:0]` there and leaves the upper 32 bits of that entry unchanged. `wrData[63:32]` is ignored.
- R5: With `wideRegs` low, a 32-bit write to an odd index x stores `wrData[31:0]` in the upper half of entry x with bit 0 cleared, and leaves that entry's lower 32 bits unchanged.
- R6: A 64-bit access uses entry x with bit 0 forced to zero when `wideRegs` is low, and entry x exactly as given when `wideRegs` is high.
- R7: A 64-bit write replaces all 64 bits of the target entry with `wrData`, with no merging, and a 64-bit read returns all 64 bits.
- R8: Reads are combinational. The contents change only on a rising clock edge with `wrEn` high. With `wrEn` low, the contents stay unchanged whatever the other write inputs do.
- R9: A read of the entry being written in the same cycle returns the old contents. The new value becomes visible only after the clock edge.
- R10: The two read ports work independently and at the same time, each with its own index and width flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes take effect on the rising edge |
| rst_n | input | 1 | Active-low reset; clears every entry |
| wideRegs | input | 1 | 1: independent 64-bit entries; 0: 32-bit compatibility pairing |
| wrEn | input | 1 | Write enable |
| wrDbl | input | 1 | Write width: 1 = 64-bit, 0 = 32-bit |
| wrIdx | input | 5 | Write register index |
| wrData | input | 64 | Write data; a 32-bit write uses bits [31:0] |
| rdDblA | input | 1 | Port A read width: 1 = 64-bit, 0 = 32-bit |
| rdIdxA | input | 5 | Port A register index |
| rdDataA | output | 64 | Port A read data; a 32-bit read is zero-extended |
| rdDblB | input | 1 | Port B read width |
| rdIdxB | input | 5 | Port B register index |
| rdDataB | output | 64 | Port B read data |

## Verification
The hardest case to reach from the ports is a half-entry merge that has to keep a non-zero neighbour half. In compatibility mode the bench first fills an even entry with a full 64-bit pattern. It then writes the odd single and then the even single, and reads the entry back as a double after each step, so a merge that clobbers either half shows up in a distinct bit pattern. Mode switches between writes and reads of the same indices check that one stored entry is seen through both mappings. A write and a read of the same entry in one cycle, sampled before and after the edge, exposes any bypass.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
  localparam int RD_PORTS = 2;

  // Strobes from the index-mapping control into the storage datapath
  typedef struct packed {
    logic                wrLoEn;   // write low half of the target entry
    logic                wrHiEn;   // write high half of the target entry
    logic                hiFromLo; // high half takes wrData low bits
    logic [RD_PORTS-1:0] rdHi;     // 32-bit read takes the high half
    logic [RD_PORTS-1:0] rdDbl;    // 64-bit read
  } fprStrobe_t;
endpackage

// File: rtl/fpr_ctrl.sv
module fpr_ctrl
  import fpr_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             wideRegs,
  input  logic             wrEn,
  input  logic             wrDbl,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [IDX_W-1:0] rdIdx   [RD_PORTS],
  input  logic             rdDbl   [RD_PORTS],
  output fprStrobe_t       stb,
  output logic [IDX_W-1:0] wrEntry,
  output logic [IDX_W-1:0] rdEntry [RD_PORTS]
);
  // In compatibility mode every access lands on the even entry of a pair
  function automatic logic [IDX_W-1:0] mapEntry(input logic [IDX_W-1:0] idx, input logic wide);
    return wide ? idx : {idx[IDX_W-1:1], 1'b0};
  endfunction

  logic oddCompatWr;

  always_comb begin
    oddCompatWr  = !wideRegs && wrIdx[0];
    wrEntry      = mapEntry(wrIdx, wideRegs);
    stb.wrLoEn   = wrEn && (wrDbl || !oddCompatWr);
    stb.wrHiEn   = wrEn && (wrDbl || oddCompatWr);
    stb.hiFromLo = !wrDbl;
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : gRdMap
    always_comb begin
      rdEntry[p]   = mapEntry(rdIdx[p], wideRegs);
      stb.rdHi[p]  = !rdDbl[p] && !wideRegs && rdIdx[p][0];
      stb.rdDbl[p] = rdDbl[p];
    end
  end
endmodule

// File: rtl/fpr_store.sv
module fpr_store
  import fpr_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 64,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int HALF_W  = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fprStrobe_t        stb,
  input  logic [IDX_W-1:0]  wrEntry,
  input  logic [DATA_W-1:0] wrData,
  input  logic [IDX_W-1:0]  rdEntry [RD_PORTS],
  output logic [DATA_W-1:0] rdData  [RD_PORTS]
);
  logic [HALF_W-1:0] loQ [NUM_REGS];
  logic [HALF_W-1:0] hiQ [NUM_REGS];
  logic [HALF_W-1:0] hiWrVal;

  assign hiWrVal = stb.hiFromLo ? wrData[HALF_W-1:0] : wrData[DATA_W-1:HALF_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        loQ[i] <= '0;
        hiQ[i] <= '0;
      end
    end else begin
      if (stb.wrLoEn) loQ[wrEntry] <= wrData[HALF_W-1:0];
      if (stb.wrHiEn) hiQ[wrEntry] <= hiWrVal;
    end
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : gRdPort
    always_comb begin
      if (stb.rdDbl[p])
        rdData[p] = {hiQ[rdEntry[p]], loQ[rdEntry[p]]};
      else if (stb.rdHi[p])
        rdData[p] = {{HALF_W{1'b0}}, hiQ[rdEntry[p]]};
      else
        rdData[p] = {{HALF_W{1'b0}}, loQ[rdEntry[p]]};
    end
  end
endmodule

// File: rtl/fpr_pair_file.sv
module fpr_pair_file
  import fpr_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 64,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wideRegs,
  input  logic              wrEn,
  input  logic              wrDbl,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdDblA,
  input  logic [IDX_W-1:0]  rdIdxA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic              rdDblB,
  input  logic [IDX_W-1:0]  rdIdxB,
  output logic [DATA_W-1:0] rdDataB
);
  fprStrobe_t        stb;
  logic [IDX_W-1:0]  wrEntry;
  logic [IDX_W-1:0]  rdIdx   [RD_PORTS];
  logic              rdDbl   [RD_PORTS];
  logic [IDX_W-1:0]  rdEntry [RD_PORTS];
  logic [DATA_W-1:0] rdData  [RD_PORTS];

  assign rdIdx[0] = rdIdxA;
  assign rdIdx[1] = rdIdxB;
  assign rdDbl[0] = rdDblA;
  assign rdDbl[1] = rdDblB;
  assign rdDataA  = rdData[0];
  assign rdDataB  = rdData[1];

  fpr_ctrl #(.IDX_W(IDX_W)) uCtrl (
    .wideRegs(wideRegs), .wrEn(wrEn), .wrDbl(wrDbl), .wrIdx(wrIdx),
    .rdIdx(rdIdx), .rdDbl(rdDbl), .stb(stb), .wrEntry(wrEntry), .rdEntry(rdEntry)
  );

  fpr_store #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) uStore (
    .clk(clk), .rst_n(rst_n), .stb(stb), .wrEntry(wrEntry), .wrData(wrData),
    .rdEntry(rdEntry), .rdData(rdData)
  );
endmodule

// File: rtl/fpr_pair_file_chk.sv
module fpr_pair_file_chk #(
  parameter int IDX_W  = 5,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wideRegs,
  input logic              wrEn,
  input logic              wrDbl,
  input logic [IDX_W-1:0]  wrIdx,
  input logic [DATA_W-1:0] wrData,
  input logic              rdDblA,
  input logic [IDX_W-1:0]  rdIdxA,
  input logic [DATA_W-1:0] rdDataA,
  input logic              rdDblB,
  input logic [IDX_W-1:0]  rdIdxB,
  input logic [DATA_W-1:0] rdDataB
);
  localparam int HALF_W = DATA_W / 2;

  // R2
  narrow_read_zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rdDblA |-> rdDataA[DATA_W-1:HALF_W] == '0);

  // R3
  odd_single_is_pair_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wideRegs && !rdDblA && rdIdxA[0] && rdDblB && rdIdxB == {rdIdxA[IDX_W-1:1], 1'b0})
      |-> rdDataA[HALF_W-1:0] == rdDataB[DATA_W-1:HALF_W]);

  // R6
  compat_double_ignores_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wideRegs && rdDblA && rdDblB && (rdIdxA ^ rdIdxB) == IDX_W'(1)) |-> rdDataA == rdDataB);

  // R7
  wide_double_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wrEn && wrDbl && wideRegs) && wideRegs && rdDblA
      && rdIdxA == $past(wrIdx)) |-> rdDataA == $past(wrData));

  // R8
  idle_write_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(wrEn) && $stable(rdIdxA) && $stable(rdDblA) && $stable(wideRegs))
      |-> $stable(rdDataA));
endmodule

bind fpr_pair_file fpr_pair_file_chk #(.IDX_W(IDX_W), .DATA_W(DATA_W)) uChk (
  .clk(clk), .rst_n(rst_n), .wideRegs(wideRegs), .wrEn(wrEn), .wrDbl(wrDbl),
  .wrIdx(wrIdx), .wrData(wrData), .rdDblA(rdDblA), .rdIdxA(rdIdxA), .rdDataA(rdDataA),
  .rdDblB(rdDblB), .rdIdxB(rdIdxB), .rdDataB(rdDataB)
);

// File: tb/sim_fpr_pair_file.sv
`timescale 1ns/1ps
module sim_fpr_pair_file;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wideRegs = 1'b1, wrEn = 1'b0, wrDbl = 1'b0;
  logic [4:0]  wrIdx = '0, rdIdxA = '0, rdIdxB = '0;
  logic [63:0] wrData = '0;
  logic        rdDblA = 1'b0, rdDblB = 1'b0;
  logic [63:0] rdDataA, rdDataB;
  int errCnt = 0, chkCnt = 0;

  always #4 clk = ~clk;

  fpr_pair_file u0 (
    .clk(clk), .rst_n(rst_n), .wideRegs(wideRegs), .wrEn(wrEn), .wrDbl(wrDbl),
    .wrIdx(wrIdx), .wrData(wrData), .rdDblA(rdDblA), .rdIdxA(rdIdxA), .rdDataA(rdDataA),
    .rdDblB(rdDblB), .rdIdxB(rdIdxB), .rdDataB(rdDataB)
  );

  typedef struct packed {
    logic        mode;
    logic        we;
    logic        wdbl;
    logic [4:0]  widx;
    logic [63:0] wdata;
    logic        rdbl;
    logic [4:0]  ridx;
    logic [63:0] expv;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 1'b1, 1'b1, 5'd3, 64'h1111_2222_3333_4444, 1'b1, 5'd3, 64'h1111_2222_3333_4444, 8'd7}, // R7
    '{1'b1, 1'b1, 1'b0, 5'd3, 64'hFFFF_FFFF_AAAA_0001, 1'b1, 5'd3, 64'h1111_2222_AAAA_0001, 8'd4}, // R4
    '{1'b1, 1'b0, 1'b0, 5'd0, 64'h0,                   1'b0, 5'd3, 64'h0000_0000_AAAA_0001, 8'd2}, // R2
    '{1'b0, 1'b1, 1'b1, 5'd5, 64'h5555_6666_7777_8888, 1'b1, 5'd4, 64'h5555_6666_7777_8888, 8'd6}, // R6
    '{1'b0, 1'b1, 1'b0, 5'd5, 64'h0000_0000_CAFE_0005, 1'b1, 5'd4, 64'hCAFE_0005_7777_8888, 8'd5}, // R5
    '{1'b0, 1'b1, 1'b0, 5'd4, 64'h0000_0000_BEEF_0004, 1'b1, 5'd4, 64'hCAFE_0005_BEEF_0004, 8'd4}, // R4
    '{1'b0, 1'b0, 1'b0, 5'd0, 64'h0,                   1'b0, 5'd5, 64'h0000_0000_CAFE_0005, 8'd3}, // R3
    '{1'b0, 1'b0, 1'b0, 5'd0, 64'h0,                   1'b0, 5'd4, 64'h0000_0000_BEEF_0004, 8'd3}, // R3
    '{1'b1, 1'b0, 1'b0, 5'd0, 64'h0,                   1'b1, 5'd5, 64'h0,                   8'd6}, // R6
    '{1'b1, 1'b1, 1'b1, 5'd2, 64'h0123_4567_89AB_CDEF, 1'b1, 5'd2, 64'h0123_4567_89AB_CDEF, 8'd7}, // R7
    '{1'b0, 1'b0, 1'b0, 5'd0, 64'h0,                   1'b0, 5'd3, 64'h0000_0000_0123_4567, 8'd3}, // R3
    '{1'b0, 1'b0, 1'b0, 5'd0, 64'h0,                   1'b1, 5'd3, 64'h0123_4567_89AB_CDEF, 8'd6}, // R6
    '{1'b1, 1'b0, 1'b0, 5'd0, 64'h0,                   1'b0, 5'd2, 64'h0000_0000_89AB_CDEF, 8'd2}  // R2
  };

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] expv);
    chkCnt++;
    if (got !== expv) begin
      errCnt++;
      $display("FAIL %s: got %h expected %h", req, got, expv);
    end
  endtask

  initial begin
    #(8 * 200000);
    errCnt++;
    chkCnt++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1: cleared after reset
    rdDblA = 1'b1; rdIdxA = 5'd0; rdDblB = 1'b0; rdIdxB = 5'd31;
    #1;
    check("R1", rdDataA, 64'h0);
    check("R1", rdDataB, 64'h0);

    foreach (VEC[k]) begin
      @(negedge clk);
      wideRegs = VEC[k].mode; wrEn = VEC[k].we; wrDbl = VEC[k].wdbl;
      wrIdx = VEC[k].widx; wrData = VEC[k].wdata;
      @(posedge clk);
      #2;
      wrEn = 1'b0;
      rdDblA = VEC[k].rdbl; rdIdxA = VEC[k].ridx;
      #1;
      check($sformatf("R%0d row%0d", VEC[k].req, k), rdDataA, VEC[k].expv);
    end

    // R9: same-cycle read sees old contents, new after the edge
    @(negedge clk);
    wideRegs = 1'b1; wrEn = 1'b1; wrDbl = 1'b1; wrIdx = 5'd3; wrData = 64'hDEAD_BEEF_0BAD_F00D;
    rdDblA = 1'b1; rdIdxA = 5'd3;
    #1;
    check("R9 before edge", rdDataA, 64'h1111_2222_AAAA_0001);
    @(posedge clk);
    #2;
    wrEn = 1'b0;
    #1;
    check("R9 after edge", rdDataA, 64'hDEAD_BEEF_0BAD_F00D);

    // R8: write inputs toggling with wrEn low change nothing
    @(negedge clk);
    wrEn = 1'b0; wrDbl = 1'b1; wrIdx = 5'd3; wrData = 64'h0;
    @(posedge clk);
    @(posedge clk);
    #2;
    check("R8 idle write", rdDataA, 64'hDEAD_BEEF_0BAD_F00D);

    // R10: two ports read different entries and widths at once
    @(negedge clk);
    wideRegs = 1'b0;
    rdDblA = 1'b0; rdIdxA = 5'd5; rdDblB = 1'b1; rdIdxB = 5'd2;
    #1;
    check("R10 portA", rdDataA, 64'h0000_0000_CAFE_0005);
    check("R10 portB", rdDataB, 64'h0123_4567_89AB_CDEF);

    // R1: reset mid-run clears written entries
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wideRegs = 1'b1; rdDblA = 1'b1; rdIdxA = 5'd3; rdDblB = 1'b1; rdIdxB = 5'd4;
    #1;
    check("R1 reset entry3", rdDataA, 64'h0);
    check("R1 reset entry4", rdDataB, 64'h0);

    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end
endmodule